// File: doc/BRIEF.md
# Indirect-address DMA transfer engine

A single DMA channel whose source register holds the location of a pointer rather than the data itself. For every unit it moves, the engine fetches a full address word from the source location, latches it, reads the data found at that latched address, and writes the data to the destination. One unit therefore costs three bus phases: pointer fetch, data read and data write. On a 16-bit bus the pointer fetch is itself two consecutive half-word reads that are combined into one 32-bit address.

Software programs source, destination, count and control through a simple write port, then pulses start. The engine drives a synchronous memory-master bus (address, read and write strobes, chip select, byte enables, write data) and honours a ready input, so each phase may be stretched by any number of wait cycles. An acknowledge output marks the data-read and data-write phases and follows chip select exactly. A one-cycle done pulse ends a run. Bad configurations raise a sticky error flag instead of running. Indirect mode exists only on the channel instance whose index parameter is 3; any other instance ignores the indirect bit and performs plain two-phase read/write transfers.

Top module: `ind_dma_engine`

## Requirements
- R1: After reset busy_o, done_o, err_o, dack_o and bus_cs_o are low.
- R2: Register select codes are 0 source, 1 destination, 2 count and 3 control. Control bit 0 requests indirect mode. Bits 2:1 give the unit: 0 byte, 1 word, 2 sixteen-byte, 3 reserved. Bit 3 enables destination increment. For indirect mode, each transfer is a read at source (upper half of the pointer), a read at source+2 (lower half), a read at the assembled pointer, then a write at the destination, strictly in that order. Read and write strobes are never high together.
- R3: The destination receives the data found at the pointer, never the pointer value itself.
- R4: dack_o is high in every cycle of the data-read and data-write phases, and it is low during pointer-fetch phases. dack_o is never high without bus_cs_o.
- R5: While bus_cs_o is high and bus_ready_i is low, address, strobes, byte enables and write data hold. A phase completes only in a cycle where bus_ready_i is high.
- R6: A start with unit code 2 or 3 runs no bus cycle. It sets err_o and produces no done pulse.
- R7: After each completed transfer the source advances by 4 in indirect mode. The destination advances by the unit size (1 or 2) when control bit 3 is set and stays fixed otherwise. The count drops by one.
- R8: After the last write of a run, done_o is high for exactly one cycle. busy_o is low in that cycle.
- R9: A byte unit at an address with bit 0 clear uses byte enable 01 and data bits 7:0. A byte unit at an address with bit 0 set uses byte enable 10 and bits 15:8. A byte write drives the byte on both lanes.
- R10: Some starts are refused with err_o set and no bus cycle: a word unit with an odd destination, or an odd source in indirect mode or in word mode. A fetched pointer that is odd for a word unit sets err_o and aborts right after the pointer fetch, with no data cycle and no done pulse.
- R11: A start pulse while busy_o is high has no effect on the running transfer sequence or its length.
- R12: A start with count 0 runs no bus cycle. It gives a done pulse in the next cycle.
- R13: An instance whose channel index is not 3 ignores control bit 0. It runs two-phase transfers (read at source, write at destination, both with dack_o), and its source advances by the unit size.
- R14: err_o holds until the next start. A start that is accepted clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe (ignored while busy) |
| reg_sel_i | input | 2 | Register select |
| reg_wdata_i | input | AW | Register write data |
| start_i | input | 1 | Start request |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| err_o | output | 1 | Sticky configuration or alignment error |
| bus_addr_o | output | AW | Bus byte address |
| bus_rd_o | output | 1 | Read strobe |
| bus_wr_o | output | 1 | Write strobe |
| bus_cs_o | output | 1 | Chip select, high in any bus phase |
| bus_be_o | output | DW/8 | Byte enables |
| bus_wdata_o | output | DW | Write data |
| bus_rdata_i | input | DW | Read data |
| bus_ready_i | input | 1 | Phase completes when high |
| dack_o | output | 1 | Acknowledge, data phases only |

## Verification
The bench builds two instances with a 32-bit address and a 16-bit bus. The first keeps channel index 3, so the two-beat pointer assembly, the odd-pointer abort and both byte lanes can be reached. The second is built with channel index 0, so the ignored indirect bit and the two-phase direct path can be observed from the same stimulus. Per-run wait counts of 0, 1 and 2 cycles in the memory model exercise phase stretching, and the cycle count of a waited run measures it.

// File: rtl/ind_dma_pkg.sv
package ind_dma_pkg;

  typedef enum logic [1:0] {
    UNIT_BYTE  = 2'd0,
    UNIT_WORD  = 2'd1,
    UNIT_BLK16 = 2'd2,
    UNIT_RSVD  = 2'd3
  } unit_e;

  typedef struct packed {
    logic  dst_inc;
    unit_e unit;
    logic  ind_en;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  typedef enum logic [1:0] {
    SEL_SRC  = 2'd0,
    SEL_DST  = 2'd1,
    SEL_CNT  = 2'd2,
    SEL_CTRL = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_PTR  = 2'd1,
    PH_RD   = 2'd2,
    PH_WR   = 2'd3
  } phase_e;

  // only this channel index may run pointer-based transfers
  localparam int IND_CHAN = 3;

endpackage

// File: rtl/ind_dma_regs.sv
module ind_dma_regs
  import ind_dma_pkg::*;
#(
  parameter int AW    = 32,
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [1:0]       sel_i,
  input  logic [AW-1:0]    wdata_i,
  input  logic             lock_i,
  input  logic             adv_i,
  input  logic [AW-1:0]    src_step_i,
  input  logic [AW-1:0]    dst_step_i,
  output logic [AW-1:0]    src_o,
  output logic [AW-1:0]    dst_o,
  output logic [CNT_W-1:0] cnt_o,
  output ctrl_t            ctrl_o
);

  logic [AW-1:0]    src_q, dst_q;
  logic [CNT_W-1:0] cnt_q;
  ctrl_t            ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q  <= '0;
      dst_q  <= '0;
      cnt_q  <= '0;
      ctrl_q <= '0;
    end else if (adv_i) begin
      src_q <= src_q + src_step_i;
      dst_q <= dst_q + dst_step_i;
      cnt_q <= cnt_q - CNT_W'(1);
    end else if (we_i && !lock_i) begin
      unique case (reg_sel_e'(sel_i))
        SEL_SRC:  src_q  <= wdata_i;
        SEL_DST:  dst_q  <= wdata_i;
        SEL_CNT:  cnt_q  <= wdata_i[CNT_W-1:0];
        SEL_CTRL: ctrl_q <= ctrl_t'(wdata_i[CTRL_W-1:0]);
        default:  ;
      endcase
    end
  end

  assign src_o  = src_q;
  assign dst_o  = dst_q;
  assign cnt_o  = cnt_q;
  assign ctrl_o = ctrl_q;

endmodule

// File: rtl/ind_dma_lane.sv
module ind_dma_lane #(
  parameter int DW = 16,
  parameter int LB = 1
) (
  input  logic            word_i,
  input  logic [LB-1:0]   lsb_i,
  input  logic [DW-1:0]   rdata_i,
  input  logic [DW-1:0]   data_i,
  output logic [DW/8-1:0] be_o,
  output logic [DW-1:0]   cap_o,
  output logic [DW-1:0]   wdata_o
);

  localparam int NB = DW / 8;

  logic [7:0] sel_byte;

  always_comb begin
    sel_byte = rdata_i[8*int'(lsb_i) +: 8];
    if (word_i) begin
      be_o  = '1;
      cap_o = rdata_i;
    end else begin
      be_o  = NB'(1) << lsb_i;
      cap_o = DW'(sel_byte);
    end
  end

  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign wdata_o[8*g +: 8] = word_i ? data_i[8*g +: 8] : data_i[7:0];
  end

endmodule

// File: rtl/ind_dma_seq.sv
module ind_dma_seq
  import ind_dma_pkg::*;
#(
  parameter int AW      = 32,
  parameter int DW      = 16,
  parameter int CNT_W   = 16,
  parameter int CHAN_ID = 3,
  parameter int LB      = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  ctrl_t            ctrl_i,
  input  logic [AW-1:0]    src_i,
  input  logic [AW-1:0]    dst_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             ready_i,
  input  logic [DW-1:0]    rdata_i,
  input  logic [DW-1:0]    cap_i,
  output logic [AW-1:0]    addr_o,
  output logic             rd_o,
  output logic             wr_o,
  output logic             ack_o,
  output logic             word_o,
  output logic [DW-1:0]    data_o,
  output logic             adv_o,
  output logic [AW-1:0]    src_step_o,
  output logic [AW-1:0]    dst_step_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o
);

  localparam int NB        = DW / 8;
  localparam int PTR_BEATS = AW / DW;
  localparam int BW        = (PTR_BEATS > 1) ? $clog2(PTR_BEATS) : 1;
  localparam int PTR_BYTES = AW / 8;
  localparam logic [BW-1:0] LAST_BEAT = BW'(PTR_BEATS - 1);
  localparam bit IND_OK = (CHAN_ID == IND_CHAN);

  phase_e        ph_q;
  logic [BW-1:0] beat_q;
  logic [AW-1:0] ptr_q;
  logic [DW-1:0] data_q;
  logic          err_q, done_q;

  logic          ind_eff, word, unit_bad, mis_start, bad_start, ptr_odd, last_xfer;
  logic [AW-1:0] ptr_next, size_bytes, beat_off;
  phase_e        first_ph;

  always_comb begin
    ind_eff    = IND_OK && ctrl_i.ind_en;
    word       = (ctrl_i.unit == UNIT_WORD);
    unit_bad   = (ctrl_i.unit == UNIT_BLK16) || (ctrl_i.unit == UNIT_RSVD);
    size_bytes = word ? AW'(NB) : AW'(1);
    mis_start  = (word && (dst_i[LB-1:0] != '0)) ||
                 ((ind_eff || word) && (src_i[LB-1:0] != '0));
    bad_start  = unit_bad || mis_start;
    ptr_next   = {ptr_q[AW-DW-1:0], rdata_i};
    ptr_odd    = word && (ptr_next[LB-1:0] != '0);
    last_xfer  = (cnt_i == CNT_W'(1));
    first_ph   = ind_eff ? PH_PTR : PH_RD;
    beat_off   = AW'(beat_q) << LB;
  end

  always_comb begin
    unique case (ph_q)
      PH_PTR:  addr_o = src_i + beat_off;
      PH_RD:   addr_o = ind_eff ? ptr_q : src_i;
      PH_WR:   addr_o = dst_i;
      default: addr_o = '0;
    endcase
  end

  assign rd_o       = (ph_q == PH_PTR) || (ph_q == PH_RD);
  assign wr_o       = (ph_q == PH_WR);
  assign ack_o      = (ph_q == PH_RD) || (ph_q == PH_WR);
  assign adv_o      = (ph_q == PH_WR) && ready_i;
  assign src_step_o = ind_eff ? AW'(PTR_BYTES) : size_bytes;
  assign dst_step_o = ctrl_i.dst_inc ? size_bytes : '0;
  assign word_o     = word;
  assign data_o     = data_q;
  assign busy_o     = (ph_q != PH_IDLE);
  assign done_o     = done_q;
  assign err_o      = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_IDLE;
      beat_q <= '0;
      ptr_q  <= '0;
      data_q <= '0;
      err_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (ph_q)
        PH_IDLE: begin
          if (start_i) begin
            err_q <= bad_start;
            if (!bad_start) begin
              if (cnt_i == '0) begin
                done_q <= 1'b1;
              end else begin
                ph_q   <= first_ph;
                beat_q <= '0;
              end
            end
          end
        end
        PH_PTR: begin
          if (ready_i) begin
            ptr_q <= ptr_next;
            if (beat_q == LAST_BEAT) begin
              if (ptr_odd) begin
                err_q <= 1'b1;
                ph_q  <= PH_IDLE;
              end else begin
                ph_q <= PH_RD;
              end
            end else begin
              beat_q <= beat_q + BW'(1);
            end
          end
        end
        PH_RD: begin
          if (ready_i) begin
            data_q <= cap_i;
            ph_q   <= PH_WR;
          end
        end
        PH_WR: begin
          if (ready_i) begin
            if (last_xfer) begin
              done_q <= 1'b1;
              ph_q   <= PH_IDLE;
            end else begin
              ph_q   <= first_ph;
              beat_q <= '0;
            end
          end
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ind_dma_engine.sv
module ind_dma_engine
  import ind_dma_pkg::*;
#(
  parameter int AW      = 32,
  parameter int DW      = 16,
  parameter int CNT_W   = 16,
  parameter int CHAN_ID = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            reg_we_i,
  input  logic [1:0]      reg_sel_i,
  input  logic [AW-1:0]   reg_wdata_i,
  input  logic            start_i,
  output logic            busy_o,
  output logic            done_o,
  output logic            err_o,
  output logic [AW-1:0]   bus_addr_o,
  output logic            bus_rd_o,
  output logic            bus_wr_o,
  output logic            bus_cs_o,
  output logic [DW/8-1:0] bus_be_o,
  output logic [DW-1:0]   bus_wdata_o,
  input  logic [DW-1:0]   bus_rdata_i,
  input  logic            bus_ready_i,
  output logic            dack_o
);

  localparam int NB = DW / 8;
  localparam int LB = (NB > 1) ? $clog2(NB) : 1;

  logic [AW-1:0]    src, dst, src_step, dst_step;
  logic [CNT_W-1:0] cnt;
  ctrl_t            ctrl;
  logic             adv, busy, word;
  logic             rd, wr, ack;
  logic [DW-1:0]    data, cap;
  logic [AW-1:0]    addr;

  ind_dma_regs #(.AW(AW), .CNT_W(CNT_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (reg_we_i),
    .sel_i      (reg_sel_i),
    .wdata_i    (reg_wdata_i),
    .lock_i     (busy),
    .adv_i      (adv),
    .src_step_i (src_step),
    .dst_step_i (dst_step),
    .src_o      (src),
    .dst_o      (dst),
    .cnt_o      (cnt),
    .ctrl_o     (ctrl)
  );

  ind_dma_seq #(
    .AW(AW), .DW(DW), .CNT_W(CNT_W), .CHAN_ID(CHAN_ID), .LB(LB)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .ctrl_i     (ctrl),
    .src_i      (src),
    .dst_i      (dst),
    .cnt_i      (cnt),
    .ready_i    (bus_ready_i),
    .rdata_i    (bus_rdata_i),
    .cap_i      (cap),
    .addr_o     (addr),
    .rd_o       (rd),
    .wr_o       (wr),
    .ack_o      (ack),
    .word_o     (word),
    .data_o     (data),
    .adv_o      (adv),
    .src_step_o (src_step),
    .dst_step_o (dst_step),
    .busy_o     (busy),
    .done_o     (done_o),
    .err_o      (err_o)
  );

  ind_dma_lane #(.DW(DW), .LB(LB)) u_lane (
    .word_i  (word),
    .lsb_i   (addr[LB-1:0]),
    .rdata_i (bus_rdata_i),
    .data_i  (data),
    .be_o    (bus_be_o),
    .cap_o   (cap),
    .wdata_o (bus_wdata_o)
  );

  assign bus_addr_o = addr;
  assign bus_rd_o   = rd;
  assign bus_wr_o   = wr;
  assign bus_cs_o   = rd || wr;
  assign dack_o     = ack;
  assign busy_o     = busy;

endmodule

// File: rtl/ind_dma_engine_chk.sv
module ind_dma_engine_chk #(
  parameter int AW = 32,
  parameter int DW = 16
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            start_i,
  input logic            busy_o,
  input logic            done_o,
  input logic            err_o,
  input logic [AW-1:0]   bus_addr_o,
  input logic            bus_rd_o,
  input logic            bus_wr_o,
  input logic            bus_cs_o,
  input logic [DW/8-1:0] bus_be_o,
  input logic [DW-1:0]   bus_wdata_o,
  input logic            bus_ready_i,
  input logic            dack_o
);

  AST_NO_RD_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_rd_o && bus_wr_o)); // R2

  AST_ACK_WITH_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dack_o |-> bus_cs_o); // R4

  AST_HOLD_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_cs_o && !bus_ready_i) |=> (bus_cs_o && $stable(bus_addr_o) && $stable(bus_rd_o)
      && $stable(bus_be_o) && $stable(bus_wdata_o))); // R5

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8

  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R8

  AST_BE_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_cs_o |-> (bus_be_o != '0)); // R9

  AST_ERR_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> !busy_o); // R10

  AST_ERR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !start_i) |=> err_o); // R14

endmodule

bind ind_dma_engine ind_dma_engine_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .err_o       (err_o),
  .bus_addr_o  (bus_addr_o),
  .bus_rd_o    (bus_rd_o),
  .bus_wr_o    (bus_wr_o),
  .bus_cs_o    (bus_cs_o),
  .bus_be_o    (bus_be_o),
  .bus_wdata_o (bus_wdata_o),
  .bus_ready_i (bus_ready_i),
  .dack_o      (dack_o)
);

// File: tb/ind_dma_engine_tb_top.sv
`timescale 1ns/1ps

module ind_dma_mem_model (
  input  logic        clk_i,
  input  logic [31:0] addr_i,
  input  logic        rd_i,
  input  logic        wr_i,
  input  logic [1:0]  be_i,
  input  logic [15:0] wdata_i,
  input  logic        ack_i,
  output logic [15:0] rdata_o,
  output logic        ready_o
);
  logic [15:0] mem [0:255];
  int          wait_n = 0;
  int          wcnt = 0;
  logic [31:0] log_addr [0:63];
  logic        log_wr   [0:63];
  logic        log_ack  [0:63];
  logic [1:0]  log_be   [0:63];
  int          log_n = 0;

  initial for (int i = 0; i < 256; i++) mem[i] = 16'h0;

  assign rdata_o = mem[addr_i[8:1]];
  assign ready_o = (rd_i || wr_i) && (wcnt >= wait_n);

  always @(posedge clk_i) begin
    if (rd_i || wr_i) begin
      if (ready_o) begin
        if (log_n < 64) begin
          log_addr[log_n] = addr_i;
          log_wr[log_n]   = wr_i;
          log_ack[log_n]  = ack_i;
          log_be[log_n]   = be_i;
          log_n = log_n + 1;
        end
        if (wr_i) begin
          if (be_i[0]) mem[addr_i[8:1]][7:0]  = wdata_i[7:0];
          if (be_i[1]) mem[addr_i[8:1]][15:8] = wdata_i[15:8];
        end
        wcnt <= 0;
      end else begin
        wcnt <= wcnt + 1;
      end
    end
  end
endmodule

module ind_dma_engine_tb_top;
  localparam int AW = 32;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_we = 1'b0;
  logic [1:0]    reg_sel = 2'd0;
  logic [AW-1:0] reg_wdata = '0;
  logic          start = 1'b0;

  logic          a_busy, a_done, a_err, a_rd, a_wr, a_cs, a_ready, a_ack;
  logic [AW-1:0] a_addr;
  logic [1:0]    a_be;
  logic [15:0]   a_wdata, a_rdata;
  logic          b_busy, b_done, b_err, b_rd, b_wr, b_cs, b_ready, b_ack;
  logic [AW-1:0] b_addr;
  logic [1:0]    b_be;
  logic [15:0]   b_wdata, b_rdata;

  int n_chk = 0;
  int n_err = 0;
  int a_done_n = 0;
  int b_done_n = 0;
  int a_busy_cyc = 0;

  always #2 clk = ~clk;

  ind_dma_engine #(.AW(AW), .DW(DW), .CNT_W(16), .CHAN_ID(3)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_sel_i(reg_sel),
    .reg_wdata_i(reg_wdata), .start_i(start), .busy_o(a_busy), .done_o(a_done),
    .err_o(a_err), .bus_addr_o(a_addr), .bus_rd_o(a_rd), .bus_wr_o(a_wr),
    .bus_cs_o(a_cs), .bus_be_o(a_be), .bus_wdata_o(a_wdata), .bus_rdata_i(a_rdata),
    .bus_ready_i(a_ready), .dack_o(a_ack)
  );

  ind_dma_engine #(.AW(AW), .DW(DW), .CNT_W(16), .CHAN_ID(0)) dut_d0_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_sel_i(reg_sel),
    .reg_wdata_i(reg_wdata), .start_i(start), .busy_o(b_busy), .done_o(b_done),
    .err_o(b_err), .bus_addr_o(b_addr), .bus_rd_o(b_rd), .bus_wr_o(b_wr),
    .bus_cs_o(b_cs), .bus_be_o(b_be), .bus_wdata_o(b_wdata), .bus_rdata_i(b_rdata),
    .bus_ready_i(b_ready), .dack_o(b_ack)
  );

  ind_dma_mem_model mem_a (
    .clk_i(clk), .addr_i(a_addr), .rd_i(a_rd), .wr_i(a_wr), .be_i(a_be),
    .wdata_i(a_wdata), .ack_i(a_ack), .rdata_o(a_rdata), .ready_o(a_ready)
  );

  ind_dma_mem_model mem_b (
    .clk_i(clk), .addr_i(b_addr), .rd_i(b_rd), .wr_i(b_wr), .be_i(b_be),
    .wdata_i(b_wdata), .ack_i(b_ack), .rdata_o(b_rdata), .ready_o(b_ready)
  );

  always @(posedge clk) begin
    if (a_done) a_done_n = a_done_n + 1;
    if (b_done) b_done_n = b_done_n + 1;
    if (a_busy) a_busy_cyc = a_busy_cyc + 1;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  task automatic reg_wr(input logic [1:0] sel, input logic [31:0] val);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = val;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic setup(input logic [31:0] src, input logic [31:0] dst,
                       input logic [31:0] cnt, input logic [31:0] ctrl, input int waits);
    reg_wr(2'd0, src);
    reg_wr(2'd1, dst);
    reg_wr(2'd2, cnt);
    reg_wr(2'd3, ctrl);
    mem_a.wait_n = waits;
    mem_b.wait_n = waits;
    mem_a.log_n = 0;
    mem_b.log_n = 0;
    a_done_n = 0;
    b_done_n = 0;
    a_busy_cyc = 0;
  endtask

  task automatic wait_idle();
    int guard = 0;
    @(negedge clk);
    while ((a_busy || b_busy) && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic go();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    wait_idle();
  endtask

  task automatic chk_log_a(input string tag, input int idx, input logic [31:0] addr,
                           input logic wr, input logic ack);
    chk({tag, " addr"}, mem_a.log_addr[idx], addr);
    chk({tag, " wr"}, 32'(mem_a.log_wr[idx]), 32'(wr));
    chk({tag, " dack"}, 32'(mem_a.log_ack[idx]), 32'(ack));
  endtask

  task automatic t_reset();
    chk("R1 busy", 32'(a_busy), 0);
    chk("R1 done", 32'(a_done), 0);
    chk("R1 err", 32'(a_err), 0);
    chk("R1 cs", 32'(a_cs), 0);
    chk("R1 dack", 32'(a_ack), 0);
  endtask

  task automatic t_word_indirect();
    mem_a.mem[8'h10] = 16'h0000; mem_a.mem[8'h11] = 16'h0100;
    mem_a.mem[8'h12] = 16'h0000; mem_a.mem[8'h13] = 16'h0140;
    mem_a.mem[8'h80] = 16'hBEEF; mem_a.mem[8'hA0] = 16'h1234;
    setup(32'h20, 32'h80, 2, 32'hB, 2);
    go();
    chk("R2 phase count", 32'(mem_a.log_n), 8);
    chk_log_a("R2 ptr hi", 0, 32'h20, 0, 0);
    chk_log_a("R2 ptr lo", 1, 32'h22, 0, 0);
    chk_log_a("R2 data rd", 2, 32'h100, 0, 1);
    chk_log_a("R2 data wr", 3, 32'h80, 1, 1);
    chk_log_a("R7 src step", 4, 32'h24, 0, 0);
    chk_log_a("R7 src step lo", 5, 32'h26, 0, 0);
    chk_log_a("R4 rd 2nd", 6, 32'h140, 0, 1);
    chk_log_a("R7 dst inc word", 7, 32'h82, 1, 1);
    chk("R3 dst data 1", 32'(mem_a.mem[8'h40]), 32'hBEEF);
    chk("R3 dst data 2", 32'(mem_a.mem[8'h41]), 32'h1234);
    chk("R5 busy cycles with 2 waits", 32'(a_busy_cyc), 24);
    chk("R8 done pulses", 32'(a_done_n), 1);
    chk("R8 busy low", 32'(a_busy), 0);
    chk("R14 err clear", 32'(a_err), 0);
  endtask

  task automatic t_byte_lanes();
    mem_a.mem[8'h20] = 16'h0000; mem_a.mem[8'h21] = 16'h0101;
    mem_a.mem[8'h22] = 16'h0000; mem_a.mem[8'h23] = 16'h0144;
    mem_a.mem[8'h80] = 16'hA5C3; mem_a.mem[8'hA2] = 16'h5A3C;
    mem_a.mem[8'h48] = 16'h7777; mem_a.mem[8'h49] = 16'h7777;
    setup(32'h40, 32'h91, 2, 32'h9, 1);
    go();
    chk("R9 phase count", 32'(mem_a.log_n), 8);
    chk("R9 odd rd be", 32'(mem_a.log_be[2]), 32'h2);
    chk("R9 odd wr be", 32'(mem_a.log_be[3]), 32'h2);
    chk("R9 even rd be", 32'(mem_a.log_be[6]), 32'h1);
    chk("R9 even wr be", 32'(mem_a.log_be[7]), 32'h1);
    chk("R7 dst inc byte", mem_a.log_addr[7], 32'h92);
    chk("R9 high lane byte", 32'(mem_a.mem[8'h48]), 32'hA577);
    chk("R9 low lane byte", 32'(mem_a.mem[8'h49]), 32'h773C);
  endtask

  task automatic t_blk16();
    setup(32'h20, 32'h80, 1, 32'h5, 0);
    go();
    chk("R6 err set", 32'(a_err), 1);
    chk("R6 no bus cycle", 32'(mem_a.log_n), 0);
    chk("R6 no done", 32'(a_done_n), 0);
    chk("R6 idle", 32'(a_busy), 0);
  endtask

  task automatic t_align();
    setup(32'h20, 32'h81, 1, 32'hB, 0);
    go();
    chk("R10 odd dst err", 32'(a_err), 1);
    chk("R10 odd dst no cycle", 32'(mem_a.log_n), 0);
    repeat (3) @(negedge clk);
    chk("R14 err held", 32'(a_err), 1);
    mem_a.mem[8'h28] = 16'h0000; mem_a.mem[8'h29] = 16'h0103;
    mem_a.mem[8'h40] = 16'h1111;
    setup(32'h50, 32'h80, 1, 32'hB, 0);
    go();
    chk("R10 odd ptr err", 32'(a_err), 1);
    chk("R10 abort after fetch", 32'(mem_a.log_n), 2);
    chk("R10 no done", 32'(a_done_n), 0);
    chk("R10 dst untouched", 32'(mem_a.mem[8'h40]), 32'h1111);
  endtask

  task automatic t_restart_busy();
    setup(32'h20, 32'hA0, 2, 32'h3, 1);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (5) @(negedge clk);
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    wait_idle();
    chk("R11 phase count", 32'(mem_a.log_n), 8);
    chk("R11 done pulses", 32'(a_done_n), 1);
    chk("R7 dst fixed 1", mem_a.log_addr[3], 32'hA0);
    chk("R7 dst fixed 2", mem_a.log_addr[7], 32'hA0);
    chk("R3 last write", 32'(mem_a.mem[8'h50]), 32'h1234);
    chk("R14 err cleared", 32'(a_err), 0);
  endtask

  task automatic t_count_zero();
    setup(32'h20, 32'h80, 0, 32'hB, 0);
    go();
    chk("R12 done pulse", 32'(a_done_n), 1);
    chk("R12 no bus cycle", 32'(mem_a.log_n), 0);
    chk("R12 no err", 32'(a_err), 0);
  endtask

  task automatic t_other_channel();
    mem_b.mem[8'h10] = 16'hCAFE; mem_b.mem[8'h11] = 16'hF00D;
    setup(32'h20, 32'hC0, 2, 32'hB, 0);
    go();
    chk("R13 phase count", 32'(mem_b.log_n), 4);
    chk("R13 rd addr", mem_b.log_addr[0], 32'h20);
    chk("R13 rd dack", 32'(mem_b.log_ack[0]), 1);
    chk("R13 wr addr", mem_b.log_addr[1], 32'hC0);
    chk("R13 wr flag", 32'(mem_b.log_wr[1]), 1);
    chk("R13 src step", mem_b.log_addr[2], 32'h22);
    chk("R13 data 1", 32'(mem_b.mem[8'h60]), 32'hCAFE);
    chk("R13 data 2", 32'(mem_b.mem[8'h61]), 32'hF00D);
    chk("R13 done", 32'(b_done_n), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual=running expected=finished");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_word_indirect();
    t_byte_lanes();
    t_blk16();
    t_align();
    t_restart_busy();
    t_count_zero();
    t_other_channel();
    summary();
  end

endmodule